// File: doc/BRIEF.md
# Shared Memory Port Arbiter for Core and Vector Coprocessor

This block lets a scalar core and a vector coprocessor share a single memory port that follows an OBI-style request/grant and response-valid handshake. Only one master owns the port at a time. The owner's request, address, write enable, byte enables and write data go to memory. The grant, response-valid and read data come back to the master that issued the access and to no other.

The core cannot cope with a second bus master, so the block enforces mutual exclusion outside it. A vector memory instruction may issue a long run of element accesses. The coprocessor raises a lock input for the length of the instruction. Once one of its accesses has been granted, it keeps the port until the lock drops and its last response has returned. When the port is idle and both masters ask in the same cycle, the core wins. If an access granted to the core is still waiting for its response, ownership stays with the core until that response has returned. A parameter sets how many accesses may await a response at once.

Top module: `mem_share_arb`

## Requirements
- R1: While reset is asserted, and until the synchronised reset has been released, mem_req_o, core_gnt_o and vec_gnt_o are low whatever the masters request. After reset with no requests, mem_req_o and both response-valid outputs are low.
- R2: At most one of core_gnt_o and vec_gnt_o is high in any cycle. A grant is given only in a cycle in which memory grants. The address, write enable, byte enables and write data on the memory side are those of the selected master. A master that is not granted sees its grant low.
- R3: When no access is pending and no lock is held, a core request wins over a vector request made in the same cycle.
- R4: After a vector access has been granted with vec_lock_i high, core_gnt_o stays low for as long as vec_lock_i stays high. This holds even in cycles where the coprocessor is not requesting.
- R5: Once a core access has been granted, vec_gnt_o stays low until that access's response has been returned. The earliest vector grant comes in the cycle after the core's last response.
- R6: A response (mem_rvalid_i, mem_rdata_i) is delivered on the response-valid and read-data outputs of the master that issued the pending access, and never on both masters' outputs.
- R7: No more than MAX_OUT granted accesses await a response at any time. With MAX_OUT accesses pending, mem_req_o is held low.
- R8: core_rdata_o and vec_rdata_o are zero in every cycle in which that master's response-valid is low.
- R9: When the lock is not held, ownership returns to idle arbitration once the owner's last response has been returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| core_req_i | input | 1 | Core access request |
| core_gnt_o | output | 1 | Core access accepted |
| core_addr_i | input | AW | Core address |
| core_we_i | input | 1 | Core write enable |
| core_be_i | input | DW/8 | Core byte enables |
| core_wdata_i | input | DW | Core write data |
| core_rvalid_o | output | 1 | Response valid to the core |
| core_rdata_o | output | DW | Read data to the core |
| vec_req_i | input | 1 | Coprocessor access request |
| vec_lock_i | input | 1 | Coprocessor holds the port across one vector memory instruction |
| vec_gnt_o | output | 1 | Coprocessor access accepted |
| vec_addr_i | input | AW | Coprocessor address |
| vec_we_i | input | 1 | Coprocessor write enable |
| vec_be_i | input | DW/8 | Coprocessor byte enables |
| vec_wdata_i | input | DW | Coprocessor write data |
| vec_rvalid_o | output | 1 | Response valid to the coprocessor |
| vec_rdata_o | output | DW | Read data to the coprocessor |
| mem_req_o | output | 1 | Request to memory |
| mem_gnt_i | input | 1 | Memory accepts the request |
| mem_addr_o | output | AW | Address to memory |
| mem_we_o | output | 1 | Write enable to memory |
| mem_be_o | output | DW/8 | Byte enables to memory |
| mem_wdata_o | output | DW | Write data to memory |
| mem_rvalid_i | input | 1 | Memory response valid |
| mem_rdata_i | input | DW | Memory read data |

## Verification
A wrong owner register appears at the ports in the very next cycle. It shows up as a grant to the wrong master, a core grant during a locked burst, or a response on the wrong master's outputs. A wrong pending-access count appears later, when the owner's last response returns. The port is then released one cycle early, and the other master is granted while a response is still in flight. Or the port is never released, and the waiting master is starved. Or the request is blocked one access too early or too late. The directed scenarios therefore check the exact cycle of each hand-over and of each response, not only the data.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_CORE = 2'd1,
    OWN_VEC  = 2'd2
  } owner_e;

  localparam int NUM_MST  = 2;
  localparam int MST_CORE = 0;
  localparam int MST_VEC  = 1;
endpackage

// File: rtl/arb_rst_sync.sv
module arb_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/arb_select.sv
module arb_select import arb_pkg::*; (
  input  logic   run_i,
  input  owner_e owner_i,
  input  logic   core_req_i,
  input  logic   vec_req_i,
  output owner_e sel_o
);
  always_comb begin
    sel_o = OWN_NONE;
    if (run_i) begin
      case (owner_i)
        OWN_CORE: sel_o = OWN_CORE;
        OWN_VEC:  sel_o = OWN_VEC;
        default: begin
          if (core_req_i)     sel_o = OWN_CORE;
          else if (vec_req_i) sel_o = OWN_VEC;
        end
      endcase
    end
  end
endmodule

// File: rtl/arb_track.sv
module arb_track import arb_pkg::*; #(
  parameter int MAX_OUT = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  owner_e sel_i,
  input  logic   take_i,
  input  logic   done_i,
  input  logic   vec_lock_i,
  output owner_e owner_o,
  output logic   room_o
);
  localparam int CW = $clog2(MAX_OUT + 1);

  owner_e        owner_q, owner_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_ok, keep, en;

  // a response with nothing pending is not counted
  assign done_ok = done_i && (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (take_i && !done_ok)      cnt_d = cnt_q + CW'(1);
    else if (!take_i && done_ok) cnt_d = cnt_q - CW'(1);
  end

  // the lock only pins ownership once the coprocessor has been granted
  always_comb begin
    keep = (cnt_d != '0) ||
           ((sel_i == OWN_VEC) && vec_lock_i && ((owner_q == OWN_VEC) || take_i));
    owner_d = keep ? sel_i : OWN_NONE;
  end

  assign en = take_i || done_ok || (owner_d != owner_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q <= OWN_NONE;
      cnt_q   <= '0;
    end else if (en) begin
      owner_q <= owner_d;
      cnt_q   <= cnt_d;
    end
  end

  assign owner_o = owner_q;
  assign room_o  = (cnt_q < CW'(MAX_OUT));
endmodule

// File: rtl/arb_route.sv
module arb_route import arb_pkg::*; #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic [NUM_MST-1:0]              sel_oh_i,
  input  logic [NUM_MST-1:0]              rsp_oh_i,
  input  logic                            room_i,
  input  logic [NUM_MST-1:0]              req_i,
  input  logic [NUM_MST-1:0]              we_i,
  input  logic [NUM_MST-1:0][DW/8-1:0]    be_i,
  input  logic [NUM_MST-1:0][AW-1:0]      addr_i,
  input  logic [NUM_MST-1:0][DW-1:0]      wdata_i,
  input  logic                            mem_gnt_i,
  input  logic                            mem_rvalid_i,
  input  logic [DW-1:0]                   mem_rdata_i,
  output logic                            mem_req_o,
  output logic                            mem_we_o,
  output logic [DW/8-1:0]                 mem_be_o,
  output logic [AW-1:0]                   mem_addr_o,
  output logic [DW-1:0]                   mem_wdata_o,
  output logic [NUM_MST-1:0]              gnt_o,
  output logic [NUM_MST-1:0]              rvalid_o,
  output logic [NUM_MST-1:0][DW-1:0]      rdata_o
);
  localparam int BW = DW / 8;

  always_comb begin
    mem_we_o    = 1'b0;
    mem_be_o    = '0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    for (int i = 0; i < NUM_MST; i++) begin
      mem_we_o    = mem_we_o    | (sel_oh_i[i] & we_i[i]);
      mem_be_o    = mem_be_o    | ({BW{sel_oh_i[i]}} & be_i[i]);
      mem_addr_o  = mem_addr_o  | ({AW{sel_oh_i[i]}} & addr_i[i]);
      mem_wdata_o = mem_wdata_o | ({DW{sel_oh_i[i]}} & wdata_i[i]);
    end
  end

  assign mem_req_o = room_i && |(sel_oh_i & req_i);

  for (genvar g = 0; g < NUM_MST; g++) begin : g_mst
    assign gnt_o[g]    = sel_oh_i[g] & req_i[g] & room_i & mem_gnt_i;
    assign rvalid_o[g] = rsp_oh_i[g] & mem_rvalid_i;
    assign rdata_o[g]  = {DW{rsp_oh_i[g] & mem_rvalid_i}} & mem_rdata_i;
  end
endmodule

// File: rtl/mem_share_arb.sv
module mem_share_arb import arb_pkg::*; #(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int MAX_OUT = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            core_req_i,
  output logic            core_gnt_o,
  input  logic [AW-1:0]   core_addr_i,
  input  logic            core_we_i,
  input  logic [DW/8-1:0] core_be_i,
  input  logic [DW-1:0]   core_wdata_i,
  output logic            core_rvalid_o,
  output logic [DW-1:0]   core_rdata_o,
  input  logic            vec_req_i,
  input  logic            vec_lock_i,
  output logic            vec_gnt_o,
  input  logic [AW-1:0]   vec_addr_i,
  input  logic            vec_we_i,
  input  logic [DW/8-1:0] vec_be_i,
  input  logic [DW-1:0]   vec_wdata_i,
  output logic            vec_rvalid_o,
  output logic [DW-1:0]   vec_rdata_o,
  output logic            mem_req_o,
  input  logic            mem_gnt_i,
  output logic [AW-1:0]   mem_addr_o,
  output logic            mem_we_o,
  output logic [DW/8-1:0] mem_be_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic            mem_rvalid_i,
  input  logic [DW-1:0]   mem_rdata_i
);
  localparam int BW = DW / 8;

  logic   rst_sync_n;
  owner_e sel, owner;
  logic   room;

  logic [NUM_MST-1:0]          sel_oh, rsp_oh, m_req, m_we, m_gnt, m_rvalid;
  logic [NUM_MST-1:0][BW-1:0]  m_be;
  logic [NUM_MST-1:0][AW-1:0]  m_addr;
  logic [NUM_MST-1:0][DW-1:0]  m_wdata, m_rdata;

  arb_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  arb_select u_sel (
    .run_i      (rst_sync_n),
    .owner_i    (owner),
    .core_req_i (core_req_i),
    .vec_req_i  (vec_req_i),
    .sel_o      (sel)
  );

  arb_track #(.MAX_OUT(MAX_OUT)) u_trk (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .sel_i      (sel),
    .take_i     (mem_req_o & mem_gnt_i),
    .done_i     (mem_rvalid_i),
    .vec_lock_i (vec_lock_i),
    .owner_o    (owner),
    .room_o     (room)
  );

  assign sel_oh  = {sel == OWN_VEC, sel == OWN_CORE};
  assign rsp_oh  = {owner == OWN_VEC, owner == OWN_CORE};
  assign m_req   = {vec_req_i, core_req_i};
  assign m_we    = {vec_we_i, core_we_i};
  assign m_be    = {vec_be_i, core_be_i};
  assign m_addr  = {vec_addr_i, core_addr_i};
  assign m_wdata = {vec_wdata_i, core_wdata_i};

  arb_route #(.AW(AW), .DW(DW)) u_route (
    .sel_oh_i     (sel_oh),
    .rsp_oh_i     (rsp_oh),
    .room_i       (room),
    .req_i        (m_req),
    .we_i         (m_we),
    .be_i         (m_be),
    .addr_i       (m_addr),
    .wdata_i      (m_wdata),
    .mem_gnt_i    (mem_gnt_i),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_be_o     (mem_be_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .gnt_o        (m_gnt),
    .rvalid_o     (m_rvalid),
    .rdata_o      (m_rdata)
  );

  assign core_gnt_o    = m_gnt[MST_CORE];
  assign vec_gnt_o     = m_gnt[MST_VEC];
  assign core_rvalid_o = m_rvalid[MST_CORE];
  assign vec_rvalid_o  = m_rvalid[MST_VEC];
  assign core_rdata_o  = m_rdata[MST_CORE];
  assign vec_rdata_o   = m_rdata[MST_VEC];
endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
  parameter int AW      = 32,
  parameter int MAX_OUT = 2
) (
  input logic          clk_i,
  input logic          rst_n,
  input logic          core_req,
  input logic          core_gnt,
  input logic          core_rvalid,
  input logic [AW-1:0] core_addr,
  input logic          vec_req,
  input logic          vec_lock,
  input logic          vec_gnt,
  input logic          vec_rvalid,
  input logic [AW-1:0] vec_addr,
  input logic          mem_req,
  input logic          mem_gnt,
  input logic [AW-1:0] mem_addr
);
  logic [3:0] core_pend, vec_pend;
  logic       lock_seen;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      core_pend <= '0;
      vec_pend  <= '0;
      lock_seen <= 1'b0;
    end else begin
      if (core_gnt && !core_rvalid)      core_pend <= core_pend + 4'd1;
      else if (!core_gnt && core_rvalid) core_pend <= core_pend - 4'd1;
      if (vec_gnt && !vec_rvalid)        vec_pend  <= vec_pend + 4'd1;
      else if (!vec_gnt && vec_rvalid)   vec_pend  <= vec_pend - 4'd1;
      if (!vec_lock)                     lock_seen <= 1'b0;
      else if (vec_gnt)                  lock_seen <= 1'b1;
    end
  end

  AST_SINGLE_GNT: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(core_gnt && vec_gnt)); // R2
  AST_CORE_PATH: assert property (@(posedge clk_i) disable iff (!rst_n)
    core_gnt |-> (mem_req && mem_gnt && core_req && mem_addr == core_addr)); // R2
  AST_VEC_PATH: assert property (@(posedge clk_i) disable iff (!rst_n)
    vec_gnt |-> (mem_req && mem_gnt && vec_req && mem_addr == vec_addr)); // R2
  AST_IDLE_CORE_WINS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (core_pend == 0 && vec_pend == 0 && !lock_seen && core_req && vec_req) |-> !vec_gnt); // R3
  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    (lock_seen && vec_lock) |-> !core_gnt); // R4
  AST_CORE_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_n)
    (core_pend != 0) |-> !vec_gnt); // R5
  AST_RSP_ONE: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(core_rvalid && vec_rvalid)); // R6
  AST_RSP_CORE_SRC: assert property (@(posedge clk_i) disable iff (!rst_n)
    core_rvalid |-> (core_pend != 0)); // R6
  AST_RSP_VEC_SRC: assert property (@(posedge clk_i) disable iff (!rst_n)
    vec_rvalid |-> (vec_pend != 0)); // R6
  AST_OUT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_n)
    (32'(core_pend) + 32'(vec_pend)) <= MAX_OUT); // R7
endmodule

bind mem_share_arb arb_chk #(.AW(AW), .MAX_OUT(MAX_OUT)) u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_sync_n),
  .core_req    (core_req_i),
  .core_gnt    (core_gnt_o),
  .core_rvalid (core_rvalid_o),
  .core_addr   (core_addr_i),
  .vec_req     (vec_req_i),
  .vec_lock    (vec_lock_i),
  .vec_gnt     (vec_gnt_o),
  .vec_rvalid  (vec_rvalid_o),
  .vec_addr    (vec_addr_i),
  .mem_req     (mem_req_o),
  .mem_gnt     (mem_gnt_i),
  .mem_addr    (mem_addr_o)
);

// File: tb/sim_mem_share_arb.sv
module sim_mem_share_arb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam logic [31:0] KEY = 32'h5A5A_0F0F;

  logic clk = 1'b0;
  logic rst_n;
  logic core_req, core_we, core_gnt, core_rvalid;
  logic [3:0] core_be;
  logic [31:0] core_addr, core_wdata, core_rdata;
  logic vec_req, vec_lock, vec_we, vec_gnt, vec_rvalid;
  logic [3:0] vec_be;
  logic [31:0] vec_addr, vec_wdata, vec_rdata;
  logic mem_req, mem_gnt, mem_we, mem_rvalid;
  logic [3:0] mem_be;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int total = 0;
  int bad = 0;
  int lat = 1;
  logic gnt_en = 1'b1;
  logic finished = 1'b0;

  logic [7:0]  pv;
  logic [31:0] pd [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: fixed latency, read data derived from the address
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv <= '0;
    else begin
      pv <= {pv[6:0], mem_req & mem_gnt};
      pd[0] <= mem_addr ^ KEY;
      for (int i = 1; i < 8; i++) pd[i] <= pd[i-1];
    end
  end
  assign mem_gnt    = gnt_en;
  assign mem_rvalid = pv[lat-1];
  assign mem_rdata  = pd[lat-1];

  mem_share_arb #(.AW(AW), .DW(DW), .MAX_OUT(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .core_req_i(core_req), .core_gnt_o(core_gnt), .core_addr_i(core_addr),
    .core_we_i(core_we), .core_be_i(core_be), .core_wdata_i(core_wdata),
    .core_rvalid_o(core_rvalid), .core_rdata_o(core_rdata),
    .vec_req_i(vec_req), .vec_lock_i(vec_lock), .vec_gnt_o(vec_gnt),
    .vec_addr_i(vec_addr), .vec_we_i(vec_we), .vec_be_i(vec_be),
    .vec_wdata_i(vec_wdata), .vec_rvalid_o(vec_rvalid), .vec_rdata_o(vec_rdata),
    .mem_req_o(mem_req), .mem_gnt_i(mem_gnt), .mem_addr_o(mem_addr),
    .mem_we_o(mem_we), .mem_be_o(mem_be), .mem_wdata_o(mem_wdata),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    core_req = 0; core_we = 0; core_be = 4'hF; core_addr = 0; core_wdata = 0;
    vec_req = 0; vec_lock = 0; vec_we = 0; vec_be = 4'hF; vec_addr = 0; vec_wdata = 0;
  endtask

  task automatic drain();
    idle_inputs();
    gnt_en = 1'b1;
    repeat (12) cyc();
    #1 check("R9 port quiet after drain", {63'd0, mem_req}, 64'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle_inputs();
    repeat (2) cyc();
    core_req = 1; vec_req = 1;
    #1;
    check("R1 mem_req in reset", {63'd0, mem_req}, 64'd0);
    check("R1 grants in reset", {62'd0, core_gnt, vec_gnt}, 64'd0);
    cyc();
    idle_inputs();
    rst_n = 1'b1;
    repeat (3) cyc();
    #1;
    check("R1 idle after reset", {61'd0, mem_req, core_rvalid, vec_rvalid}, 64'd0);
  endtask

  task automatic t_core_read();
    lat = 1;
    cyc(); core_req = 1; core_addr = 32'h100;
    #1;
    check("R2 core grant", {63'd0, core_gnt}, 64'd1);
    check("R2 core address on port", {32'd0, mem_addr}, {32'd0, 32'h100});
    cyc(); core_req = 0;
    #1;
    check("R6 core response valid", {62'd0, core_rvalid, vec_rvalid}, 64'd2);
    check("R6 core read data", {32'd0, core_rdata}, {32'd0, 32'h100 ^ KEY});
    check("R8 vec rdata zero", {32'd0, vec_rdata}, 64'd0);
    drain();
  endtask

  task automatic t_both_drain();
    int rv_at = 0;
    int g_at = 0;
    lat = 3;
    cyc(); core_req = 1; core_addr = 32'h200; vec_req = 1; vec_addr = 32'h300;
    #1;
    check("R3 core wins idle tie", {62'd0, core_gnt, vec_gnt}, 64'd2);
    check("R3 core address selected", {32'd0, mem_addr}, {32'd0, 32'h200});
    cyc(); core_req = 0;
    for (int k = 1; k <= 6; k++) begin
      #1;
      if (core_rvalid) rv_at = k;
      if (vec_gnt && g_at == 0) g_at = k;
      cyc();
    end
    check("R5 core response cycle", 64'(rv_at), 64'd3);
    check("R5 vector granted after core response", 64'(g_at), 64'd4);
    drain();
  endtask

  task automatic t_stall();
    lat = 1;
    cyc(); gnt_en = 0; core_req = 1; core_addr = 32'h220; vec_req = 1; vec_addr = 32'h330;
    #1;
    check("R2 no grant while memory stalls", {62'd0, core_gnt, vec_gnt}, 64'd0);
    check("R2 request forwarded while stalled", {63'd0, mem_req}, 64'd1);
    cyc(); gnt_en = 1;
    #1;
    check("R3 core granted after stall", {62'd0, core_gnt, vec_gnt}, 64'd2);
    drain();
  endtask

  task automatic t_lock();
    lat = 1;
    cyc(); vec_req = 1; vec_lock = 1; vec_addr = 32'h400;
    #1 check("R4 vector first access granted", {63'd0, vec_gnt}, 64'd1);
    cyc(); vec_req = 0; core_req = 1; core_addr = 32'h500;
    #1 check("R4 core held during locked burst", {63'd0, core_gnt}, 64'd0);
    cyc();
    #1 check("R4 core held in burst gap", {63'd0, core_gnt}, 64'd0);
    cyc(); vec_req = 1; vec_addr = 32'h404;
    #1 check("R4 vector second access, core held", {62'd0, vec_gnt, core_gnt}, 64'd2);
    cyc(); vec_req = 0; vec_lock = 0;
    #1 check("R4 core held until last response", {63'd0, core_gnt}, 64'd0);
    cyc();
    #1 check("R9 core granted after release", {63'd0, core_gnt}, 64'd1);
    drain();
  endtask

  task automatic t_write_mux();
    lat = 1;
    cyc();
    core_addr = 32'hAAAA_0000; core_we = 0; core_be = 4'b1001; core_wdata = 32'h1111_2222;
    vec_req = 1; vec_we = 1; vec_be = 4'b0110; vec_wdata = 32'hDEAD_BEEF; vec_addr = 32'h600;
    #1;
    check("R2 vector grant", {62'd0, vec_gnt, core_gnt}, 64'd2);
    check("R2 vector write fields", {27'd0, mem_we, mem_be, mem_wdata},
          {27'd0, 1'b1, 4'b0110, 32'hDEAD_BEEF});
    check("R2 vector address", {32'd0, mem_addr}, {32'd0, 32'h600});
    cyc(); vec_req = 0;
    #1;
    check("R6 vector response only", {62'd0, vec_rvalid, core_rvalid}, 64'd2);
    check("R6 vector read data", {32'd0, vec_rdata}, {32'd0, 32'h600 ^ KEY});
    check("R8 core rdata zero", {32'd0, core_rdata}, 64'd0);
    drain();
  endtask

  task automatic t_limit();
    int grants = 0;
    lat = 4;
    cyc(); vec_req = 1; vec_lock = 1; vec_addr = 32'h700;
    for (int k = 0; k < 4; k++) begin
      #1;
      if (vec_gnt) grants++;
      if (k == 3) check("R7 request blocked at limit", {63'd0, mem_req}, 64'd0);
      cyc();
    end
    #1 check("R7 first response arrives", {63'd0, vec_rvalid}, 64'd1);
    check("R7 accesses accepted before response", 64'(grants), 64'd2);
    drain();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_core_read();
    t_both_drain();
    t_stall();
    t_lock();
    t_write_mux();
    t_limit();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule